// File: doc/BRIEF.md
# Width-Aware 20-bit Register File

This block holds the sixteen general and special registers of a 20-bit microcontroller datapath. It has two combinational read ports and one write port. The write port carries a size code, so a byte, word or full 20-bit value is placed in the low bits and the rest of the register is cleared. A fourth size code stores a byte with its bit 7 copied into every upper bit. Entry 0 is the program counter, and a separate advance input adds an instruction length to it. Entry 1 is the stack pointer. Entry 2 keeps only a 16-bit status value.

Entries 2 and 3 also serve as constant sources. On a read of entry 2 with a non-zero source-mode code, or of entry 3 with any code, the port returns a value from a parameter table rather than stored contents. Entry 3 has no storage at all. The surrounding decoder supplies the register numbers, source-mode codes and size codes. The ALU and memory sit outside this block.

Top module: `widereg_file`

## Requirements
- R1: After reset every stored register reads 0x00000, and `pc_value` is 0x00000.
- R2: Size code 2'b00 (byte) stores `wr_data[7:0]` and clears bits 19:8 of the target.
- R3: Size code 2'b01 (word) stores `wr_data[15:0]` and clears bits 19:16 of the target.
- R4: Size code 2'b10 (20-bit) stores all of `wr_data[19:0]`.
- R5: Size code 2'b11 (sign-extended byte) stores `wr_data[7:0]` and fills bits 19:8 with `wr_data[7]`.
- R6: Entry 2 holds 16 bits. Bits 19:16 of a write to it are dropped, and a mode-00 read of entry 2 returns zero in bits 19:16.
- R7: A read of entry 2 returns the stored status value for source mode 2'b00. For modes 01, 10 and 11 it returns the constants 0x00000, 0x00004 and 0x00008 (default parameters).
- R8: A read of entry 3 returns 0x00000, 0x00001, 0x00002 or 0xFFFFF for source modes 00, 01, 10 and 11. A write to entry 3 has no effect.
- R9: Reads are combinational. A write shows on the read ports from the cycle after the write edge, and a read of the written entry in the write cycle returns the old value.
- R10: While `pc_adv_en` is high, entry 0 gains `pc_adv_bytes` at the clock edge, modulo 2^20. `pc_value` always shows entry 0.
- R11: A write to entry 0 in the same cycle as `pc_adv_en` takes priority, and the advance is discarded.
- R12: The two read ports work independently. The source mode has no effect on reads of entries other than 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Register number to write |
| wr_size | input | 2 | Size code: 00 byte, 01 word, 10 20-bit, 11 sign-extended byte |
| wr_data | input | 20 | Write value |
| pc_adv_en | input | 1 | Advance the program counter this cycle |
| pc_adv_bytes | input | 4 | Instruction length in bytes added on advance |
| rd0_addr | input | 4 | Read port 0 register number |
| rd0_mode | input | 2 | Read port 0 source-mode code |
| rd0_data | output | 20 | Read port 0 value |
| rd1_addr | input | 4 | Read port 1 register number |
| rd1_mode | input | 2 | Read port 1 source-mode code |
| rd1_data | output | 20 | Read port 1 value |
| pc_value | output | 20 | Current program counter (entry 0) |

## Verification
The assertions assume that every control input is a known value on each rising edge after the internal reset is released. They also assume that no input changes during the two-cycle reset synchronisation window. The bench holds all inputs idle through reset and for several cycles after it. It then drives new values only at falling edges, so every edge sees settled, known values. The random phase draws every input across its full range, including writes to entries 2 and 3, writes to entry 0 at the same time as an advance, and advances that wrap past 0xFFFFF. The directed cases set up each size code and each constant-mode code on purpose.

// File: rtl/widereg_pkg.sv
package widereg_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_ADDR = 2'b10,
    SZ_SXTB = 2'b11
  } wr_size_e;

  localparam int unsigned PC_IDX = 0;
  localparam int unsigned SR_IDX = 2;
  localparam int unsigned CG_IDX = 3;
endpackage

// File: rtl/widereg_fmt.sv
module widereg_fmt #(
  parameter int unsigned DW = 20
) (
  input  logic [1:0]    size,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  import widereg_pkg::*;

  always_comb begin
    case (wr_size_e'(size))
      SZ_BYTE: dout = {{(DW-8){1'b0}}, din[7:0]};
      SZ_WORD: dout = {{(DW-16){1'b0}}, din[15:0]};
      SZ_ADDR: dout = din;
      default: dout = {{(DW-8){din[7]}}, din[7:0]};
    endcase
  end
endmodule

// File: rtl/widereg_cell.sv
module widereg_cell #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/widereg_rdport.sv
module widereg_rdport #(
  parameter int unsigned DW   = 20,
  parameter int unsigned NREG = 16,
  parameter int unsigned AW   = 4,
  parameter logic [4*DW-1:0] CG1_K = '0,
  parameter logic [4*DW-1:0] CG2_K = '0
) (
  input  logic [NREG-1:0][DW-1:0] bank,
  input  logic [AW-1:0]           addr,
  input  logic [1:0]              mode,
  output logic [DW-1:0]           data
);
  import widereg_pkg::*;

  always_comb begin
    data = bank[addr];
    if (addr == AW'(SR_IDX) && mode != 2'b00)
      data = CG1_K[int'(mode)*DW +: DW];
    if (addr == AW'(CG_IDX))
      data = CG2_K[int'(mode)*DW +: DW];
  end
endmodule

// File: rtl/widereg_file.sv
module widereg_file #(
  parameter int unsigned DW      = 20,
  parameter int unsigned SRW     = 16,
  parameter int unsigned NREG    = 16,
  parameter int unsigned PCSTEPW = 4,
  parameter logic [4*DW-1:0] CG1_K = {20'h00008, 20'h00004, 20'h00000, 20'h00000},
  parameter logic [4*DW-1:0] CG2_K = {20'hFFFFF, 20'h00002, 20'h00001, 20'h00000},
  localparam int unsigned AW = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [1:0]         wr_size,
  input  logic [DW-1:0]      wr_data,
  input  logic               pc_adv_en,
  input  logic [PCSTEPW-1:0] pc_adv_bytes,
  input  logic [AW-1:0]      rd0_addr,
  input  logic [1:0]         rd0_mode,
  output logic [DW-1:0]      rd0_data,
  input  logic [AW-1:0]      rd1_addr,
  input  logic [1:0]         rd1_mode,
  output logic [DW-1:0]      rd1_data,
  output logic [DW-1:0]      pc_value
);
  import widereg_pkg::*;

  logic [1:0]               rst_sync_q;
  logic                     rst_int_n;
  logic [DW-1:0]            wr_val;
  logic [NREG-1:0]          ld;
  logic [NREG-1:0][DW-1:0]  nxt;
  logic [NREG-1:0][DW-1:0]  bank;
  logic [DW-1:0]            pc_step;

  // reset: asserted at once, released on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  widereg_fmt #(.DW(DW)) u_fmt (
    .size (wr_size),
    .din  (wr_data),
    .dout (wr_val)
  );

  assign pc_step = bank[PC_IDX] + DW'(pc_adv_bytes);

  // next-state: per-entry load enable and value
  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      ld[i]  = wr_en && (wr_addr == AW'(i));
      nxt[i] = wr_val;
    end
    if (!ld[PC_IDX] && pc_adv_en) begin
      ld[PC_IDX]  = 1'b1;
      nxt[PC_IDX] = pc_step;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == CG_IDX) begin : g_const
      assign bank[g] = '0;
    end else if (g == SR_IDX) begin : g_status
      logic [SRW-1:0] sr_q;
      widereg_cell #(.W(SRW)) u_cell (
        .clk   (clk),
        .rst_n (rst_int_n),
        .ld    (ld[g]),
        .d     (nxt[g][SRW-1:0]),
        .q     (sr_q)
      );
      assign bank[g] = {{(DW-SRW){1'b0}}, sr_q};
    end else begin : g_full
      widereg_cell #(.W(DW)) u_cell (
        .clk   (clk),
        .rst_n (rst_int_n),
        .ld    (ld[g]),
        .d     (nxt[g]),
        .q     (bank[g])
      );
    end
  end

  widereg_rdport #(.DW(DW), .NREG(NREG), .AW(AW), .CG1_K(CG1_K), .CG2_K(CG2_K)) u_rd0 (
    .bank (bank),
    .addr (rd0_addr),
    .mode (rd0_mode),
    .data (rd0_data)
  );

  widereg_rdport #(.DW(DW), .NREG(NREG), .AW(AW), .CG1_K(CG1_K), .CG2_K(CG2_K)) u_rd1 (
    .bank (bank),
    .addr (rd1_addr),
    .mode (rd1_mode),
    .data (rd1_data)
  );

  assign pc_value = bank[PC_IDX];
endmodule

// File: rtl/widereg_chk.sv
module widereg_chk #(
  parameter int unsigned DW      = 20,
  parameter int unsigned NREG    = 16,
  parameter int unsigned AW      = 4,
  parameter int unsigned PCSTEPW = 4
) (
  input logic                    clk,
  input logic                    rst_int_n,
  input logic                    wr_en,
  input logic [AW-1:0]           wr_addr,
  input logic [1:0]              wr_size,
  input logic [DW-1:0]           wr_data,
  input logic                    pc_adv_en,
  input logic [PCSTEPW-1:0]      pc_adv_bytes,
  input logic [AW-1:0]           rd0_addr,
  input logic [1:0]              rd0_mode,
  input logic [DW-1:0]           rd0_data,
  input logic [DW-1:0]           pc_value,
  input logic [NREG-1:0][DW-1:0] bank
);
  AST_BYTE_ZFILL: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_en && wr_size == 2'b00 && wr_addr != AW'(3) |=>
      bank[$past(wr_addr)] == {{(DW-8){1'b0}}, $past(wr_data[7:0])}); // R2

  AST_WORD_ZFILL: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_en && wr_size == 2'b01 && wr_addr != AW'(3) |=>
      bank[$past(wr_addr)] == {{(DW-16){1'b0}}, $past(wr_data[15:0])}); // R3

  AST_ADDR_FULL: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_en && wr_size == 2'b10 && wr_addr != AW'(3) && wr_addr != AW'(2) |=>
      bank[$past(wr_addr)] == $past(wr_data)); // R4

  AST_SXT_FILL: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_en && wr_size == 2'b11 && wr_addr != AW'(3) && wr_addr != AW'(2) |=>
      bank[$past(wr_addr)] == {{(DW-8){$past(wr_data[7])}}, $past(wr_data[7:0])}); // R5

  AST_STATUS_NARROW: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd0_addr == AW'(2) && rd0_mode == 2'b00 |-> rd0_data[DW-1:16] == '0); // R6

  AST_CONST_STABLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd0_addr == AW'(3) && $past(rd0_addr) == AW'(3) && rd0_mode == $past(rd0_mode)
      |-> $stable(rd0_data)); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !wr_en && !pc_adv_en |=> $stable(bank)); // R9

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_int_n)
    pc_adv_en && !(wr_en && wr_addr == AW'(0)) |=>
      pc_value == $past(pc_value) + DW'($past(pc_adv_bytes))); // R10

  AST_PC_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_int_n)
    pc_adv_en && wr_en && wr_addr == AW'(0) && wr_size == 2'b10 |=>
      pc_value == $past(wr_data)); // R11
endmodule

bind widereg_file widereg_chk #(.DW(DW), .NREG(NREG), .AW(AW), .PCSTEPW(PCSTEPW)) u_chk (.*);

// File: tb/widereg_file_tb.sv
module widereg_file_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, pc_adv_en;
  logic [3:0]  wr_addr, rd0_addr, rd1_addr, pc_adv_bytes;
  logic [1:0]  wr_size, rd0_mode, rd1_mode;
  logic [19:0] wr_data;
  logic [19:0] rd0_data, rd1_data, pc_value;

  int n_chk = 0;
  int n_bad = 0;
  logic [19:0] model [16];

  always #2 clk = ~clk;

  widereg_file u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_size(wr_size),
    .wr_data(wr_data), .pc_adv_en(pc_adv_en), .pc_adv_bytes(pc_adv_bytes),
    .rd0_addr(rd0_addr), .rd0_mode(rd0_mode), .rd0_data(rd0_data),
    .rd1_addr(rd1_addr), .rd1_mode(rd1_mode), .rd1_data(rd1_data),
    .pc_value(pc_value)
  );

  function automatic logic [19:0] f_fmt(logic [1:0] sz, logic [19:0] d);
    case (sz)
      2'b00:   return {12'h000, d[7:0]};
      2'b01:   return {4'h0, d[15:0]};
      2'b10:   return d;
      default: return {{12{d[7]}}, d[7:0]};
    endcase
  endfunction

  function automatic logic [19:0] f_rd(logic [3:0] a, logic [1:0] m);
    if (a == 4'd2) begin
      case (m)
        2'b00:   return model[2];
        2'b01:   return 20'h00000;
        2'b10:   return 20'h00004;
        default: return 20'h00008;
      endcase
    end
    if (a == 4'd3) begin
      case (m)
        2'b00:   return 20'h00000;
        2'b01:   return 20'h00001;
        2'b10:   return 20'h00002;
        default: return 20'hFFFFF;
      endcase
    end
    return model[a];
  endfunction

  task automatic chk(string req, logic [19:0] act, logic [19:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%05h expected=%05h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [3:0] wa, input logic [1:0] sz,
                     input logic [19:0] wd, input logic [3:0] a0, input logic [1:0] m0,
                     input logic [3:0] a1, input logic [1:0] m1, input logic adv,
                     input logic [3:0] step, input string req);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_size = sz; wr_data = wd;
    rd0_addr = a0; rd0_mode = m0; rd1_addr = a1; rd1_mode = m1;
    pc_adv_en = adv; pc_adv_bytes = step;
    #1;
    chk(req, rd0_data, f_rd(a0, m0));
    chk(req, rd1_data, f_rd(a1, m1));
    chk("R10 pc_value", pc_value, model[0]);
    @(posedge clk);
    if (we && wa == 4'd2)      model[2] = f_fmt(sz, wd) & 20'h0FFFF;
    else if (we && wa != 4'd3) model[wa] = f_fmt(sz, wd);
    if (adv && !(we && wa == 4'd0)) model[0] = model[0] + {16'h0, step};
  endtask

  task automatic idle_rd(input logic [3:0] a0, input logic [1:0] m0,
                         input logic [3:0] a1, input logic [1:0] m1, input string req);
    cyc(1'b0, 4'd0, 2'b00, 20'h0, a0, m0, a1, m1, 1'b0, 4'd0, req);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) model[i] = 20'h0;
    rst_n = 1'b0;
    wr_en = 0; wr_addr = 0; wr_size = 0; wr_data = 0; pc_adv_en = 0; pc_adv_bytes = 0;
    rd0_addr = 0; rd0_mode = 0; rd1_addr = 0; rd1_mode = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset contents through both ports
    for (int i = 0; i < 16; i += 2) idle_rd(4'(i), 2'b00, 4'(i + 1), 2'b00, "R1 reset");

    // R2 / R9: byte write, old value in write cycle, new value next cycle
    cyc(1'b1, 4'd5, 2'b00, 20'hABCDE, 4'd5, 2'b00, 4'd5, 2'b01, 1'b0, 4'd0, "R9 old value");
    idle_rd(4'd5, 2'b00, 4'd5, 2'b11, "R2 byte");
    // R3 word, R4 20-bit
    cyc(1'b1, 4'd6, 2'b01, 20'h9ABCD, 4'd6, 2'b00, 4'd1, 2'b00, 1'b0, 4'd0, "R9 old value");
    cyc(1'b1, 4'd7, 2'b10, 20'h9ABCD, 4'd6, 2'b00, 4'd6, 2'b10, 1'b0, 4'd0, "R3 word");
    idle_rd(4'd7, 2'b00, 4'd7, 2'b01, "R4 20-bit");
    // R5 sign-extended byte, both signs
    cyc(1'b1, 4'd8, 2'b11, 20'h12380, 4'd8, 2'b00, 4'd8, 2'b00, 1'b0, 4'd0, "R9 old value");
    cyc(1'b1, 4'd9, 2'b11, 20'hFFF7F, 4'd8, 2'b00, 4'd8, 2'b10, 1'b0, 4'd0, "R5 sxt negative");
    idle_rd(4'd9, 2'b00, 4'd9, 2'b11, "R5 sxt positive R12 mode ignored");
    // R6 status register width
    cyc(1'b1, 4'd2, 2'b10, 20'hFFFFF, 4'd2, 2'b00, 4'd2, 2'b00, 1'b0, 4'd0, "R9 old value");
    idle_rd(4'd2, 2'b00, 4'd2, 2'b01, "R6 status narrow R7");
    cyc(1'b1, 4'd2, 2'b11, 20'h00080, 4'd2, 2'b10, 4'd2, 2'b11, 1'b0, 4'd0, "R7 constants");
    idle_rd(4'd2, 2'b00, 4'd2, 2'b00, "R6 status sxt");
    // R8 entry 3 write ignored, constants
    cyc(1'b1, 4'd3, 2'b10, 20'h12345, 4'd3, 2'b00, 4'd3, 2'b01, 1'b0, 4'd0, "R8 const");
    idle_rd(4'd3, 2'b10, 4'd3, 2'b11, "R8 write ignored");
    idle_rd(4'd3, 2'b00, 4'd3, 2'b01, "R8 write ignored");
    // R10 wrap, R11 priority
    cyc(1'b1, 4'd0, 2'b10, 20'hFFFFE, 4'd0, 2'b00, 4'd1, 2'b00, 1'b0, 4'd0, "R10 setup");
    cyc(1'b0, 4'd0, 2'b00, 20'h0, 4'd0, 2'b00, 4'd0, 2'b11, 1'b1, 4'd4, "R10 pre-advance");
    idle_rd(4'd0, 2'b00, 4'd0, 2'b00, "R10 wrap");
    cyc(1'b1, 4'd0, 2'b10, 20'h31100, 4'd0, 2'b00, 4'd0, 2'b00, 1'b1, 4'd6, "R11 setup");
    idle_rd(4'd0, 2'b00, 4'd0, 2'b01, "R11 write wins");
    cyc(1'b0, 4'd0, 2'b00, 20'h0, 4'd0, 2'b00, 4'd0, 2'b00, 1'b1, 4'd2, "R10 step");
    idle_rd(4'd0, 2'b00, 4'd4, 2'b11, "R10 step R12");

    // random phase: all inputs across full range
    for (int n = 0; n < 3000; n++) begin
      cyc(1'($urandom), 4'($urandom), 2'($urandom), 20'($urandom),
          4'($urandom), 2'($urandom), 4'($urandom), 2'($urandom),
          ($urandom % 4) == 0, 4'($urandom), "R12 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule